// File: doc/BRIEF.md
# Prescaled Reloadable Down-Counter Timer

This block is a 16-bit down-counting timer with a 4-bit clock prescaler, reached through a small register port. The prescaler counts down from a programmable divide ratio. Each time it passes zero, the main counter steps down by one. When the main counter is asked to step below zero, it takes the value held in the period register. At the same moment it emits a one-clock event pulse meant for an interrupt controller.

Software sees three registers: control, period and counter. The control register carries four things: the divide ratio, the live prescaler count (read-only), a stop bit and a self-clearing reload strobe. Writing the reload strobe copies the period into the counter and the ratio into the prescaler. A stopped timer holds its state, but register writes still land. Out of reset the timer runs at full rate (ratio 0), with both period and counter at all ones.

Top module: `reload_timer`

## Requirements
- R1: After reset the control register reads 0x0000 (ratio 0, prescaler count 0, running), the period and counter registers read 0xFFFF, and `tickPulse` is low.
- R2: While running with ratio N, the counter (select 2) decreases by exactly one on every (N+1)th clock edge. The step happens on the edges where the prescaler count is 0.
- R3: A borrow occurs when the counter is at 0 and a step is due. On a borrow the counter loads the period value (select 1), and `tickPulse` is high for the one clock that follows each borrow.
- R4: On every borrow the prescaler count reloads from the divide ratio, so after a borrow the prescaler field reads back equal to the ratio.
- R5: Writing control (select 0) with bit 9 set copies the period into the counter and the newly written ratio into the prescaler. This takes effect at that clock edge, whether the timer is running or stopped. Bit 9 always reads back 0.
- R6: With control bit 8 set (stopped), the counter, the prescaler and `tickPulse` do not change, but writes to all registers still take effect.
- R7: The control register exposes the divide ratio in bits 3:0 and the prescaler count in bits 7:4. Writes to bits 7:4 are ignored.
- R8: A period write does not disturb the counter. A counter write loads the written value directly.
- R9: Select 3 reads 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 2 | Register select: 0 control, 1 period, 2 counter, 3 unused |
| wrEn | input | 1 | Write strobe for the selected register, one cycle per write |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data of the selected register (combinational) |
| tickPulse | output | 1 | One-clock timer event pulse following each borrow |

## Verification
The embedded properties assume these things about the inputs:
- `regSel` and `wrEn` are free of X.
- A write lasts exactly one clock.
- The stopped-state property applies only to cycles with no write, because writes may legally change the counter while stopped.

The stimulus holds each write for a single clock and changes inputs one time unit after the rising edge. It reads the counter and prescaler only after stopping the timer, so every expected value follows from a count of the running edges between the start write and the stop write.

// File: rtl/reload_timer_pkg.sv
package reload_timer_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_PERIOD = 2'd1,
    SEL_COUNT  = 2'd2,
    SEL_NONE   = 2'd3
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic preLoad;     // prescaler takes ratio
    logic preDec;      // prescaler steps down
    logic cntLoadWr;   // counter takes write data
    logic cntLoadPer;  // counter takes period
    logic cntDec;      // counter steps down
    logic perLoadWr;   // period takes write data
    logic evtSet;      // borrow happened
  } tmrStrobes_t;

endpackage

// File: rtl/reload_timer_ctrl.sv
module reload_timer_ctrl
  import reload_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       regSel,
  input  logic             wrEn,
  input  logic [CNT_W-1:0] wrData,
  input  logic             preZero,
  input  logic             cntZero,
  output logic [PRE_W-1:0] ratioQ,
  output logic [PRE_W-1:0] ratioNext,
  output logic             haltQ,
  output tmrStrobes_t      stb
);

  localparam int HALT_BIT   = 2 * PRE_W;
  localparam int RELOAD_BIT = 2 * PRE_W + 1;

  logic ctrlWr, cntWr, perWr, swReload, running, stepDue, borrow;

  always_comb begin
    ctrlWr   = wrEn && (regSel == SEL_CTRL);
    perWr    = wrEn && (regSel == SEL_PERIOD);
    cntWr    = wrEn && (regSel == SEL_COUNT);
    swReload = ctrlWr && wrData[RELOAD_BIT];
    running  = !haltQ;
    stepDue  = running && preZero;
    borrow   = stepDue && cntZero && !cntWr && !swReload;
    ratioNext = ctrlWr ? wrData[PRE_W-1:0] : ratioQ;
  end

  always_comb begin
    stb.preLoad    = swReload || stepDue;
    stb.preDec     = running && !preZero && !swReload;
    stb.cntLoadWr  = cntWr;
    stb.cntLoadPer = !cntWr && (swReload || borrow);
    stb.cntDec     = stepDue && !cntZero && !cntWr && !swReload;
    stb.perLoadWr  = perWr;
    stb.evtSet     = borrow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ratioQ <= '0;
      haltQ  <= 1'b0;
    end else if (ctrlWr) begin
      ratioQ <= wrData[PRE_W-1:0];
      haltQ  <= wrData[HALT_BIT];
    end
  end

  // R6: a stopped timer with no write asks for no motion
  a_r6_no_step_when_halted: assert property (@(posedge clk) disable iff (!rstN)
    (haltQ && !wrEn) |-> !(stb.preDec || stb.cntDec || stb.evtSet));

endmodule

// File: rtl/reload_timer_dp.sv
module reload_timer_dp
  import reload_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobes_t      stb,
  input  logic [PRE_W-1:0] ratioNext,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] cntQ,
  output logic [CNT_W-1:0] periodQ,
  output logic [PRE_W-1:0] preQ,
  output logic             preZero,
  output logic             cntZero,
  output logic             evtQ
);

  localparam logic [CNT_W-1:0] CNT_RESET = '1;

  assign preZero = (preQ == '0);
  assign cntZero = (cntQ == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              periodQ <= CNT_RESET;
    else if (stb.perLoadWr) periodQ <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cntQ <= CNT_RESET;
    else if (stb.cntLoadWr)  cntQ <= wrData;
    else if (stb.cntLoadPer) cntQ <= periodQ;
    else if (stb.cntDec)     cntQ <= cntQ - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            preQ <= '0;
    else if (stb.preLoad) preQ <= ratioNext;
    else if (stb.preDec)  preQ <= preQ - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) evtQ <= 1'b0;
    else       evtQ <= stb.evtSet;
  end

  // R3: each event comes with the counter refilled from the period
  a_r3_borrow_reload: assert property (@(posedge clk) disable iff (!rstN)
    evtQ |-> (cntQ == $past(periodQ)));

  // R2: outside loads the counter only ever moves down by one
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rstN)
    ((cntQ != $past(cntQ)) && !$past(stb.cntLoadWr) && !$past(stb.cntLoadPer))
      |-> (cntQ == $past(cntQ) - 1'b1));

endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import reload_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       regSel,
  input  logic             wrEn,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] rdData,
  output logic             tickPulse
);

  localparam int HALT_BIT   = 2 * PRE_W;
  localparam int RELOAD_BIT = 2 * PRE_W + 1;
  localparam int PAD_W      = CNT_W - 2 * PRE_W - 2;

  tmrStrobes_t      stb;
  logic [PRE_W-1:0] ratioQ, ratioNext, preQ;
  logic [CNT_W-1:0] cntQ, periodQ;
  logic             haltQ, preZero, cntZero;

  reload_timer_ctrl #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regSel    (regSel),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .preZero   (preZero),
    .cntZero   (cntZero),
    .ratioQ    (ratioQ),
    .ratioNext (ratioNext),
    .haltQ     (haltQ),
    .stb       (stb)
  );

  reload_timer_dp #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .ratioNext (ratioNext),
    .wrData    (wrData),
    .cntQ      (cntQ),
    .periodQ   (periodQ),
    .preQ      (preQ),
    .preZero   (preZero),
    .cntZero   (cntZero),
    .evtQ      (tickPulse)
  );

  always_comb begin
    unique case (regSel)
      SEL_CTRL:   rdData = {{PAD_W{1'b0}}, 1'b0, haltQ, preQ, ratioQ};
      SEL_PERIOD: rdData = periodQ;
      SEL_COUNT:  rdData = cntQ;
      default:    rdData = '0;
    endcase
  end

  // R6: stopped and untouched means frozen
  a_r6_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (haltQ && !wrEn) |=> ($stable(cntQ) && $stable(preQ) && !tickPulse));

  // R5: software reload fills counter and prescaler
  a_r5_sw_reload: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel == SEL_CTRL && wrData[RELOAD_BIT])
      |=> (cntQ == $past(periodQ) && preQ == ratioQ));

  // R4: after a borrow the prescaler restarts from the ratio
  a_r4_pre_on_borrow: assert property (@(posedge clk) disable iff (!rstN)
    tickPulse |-> (preQ == ratioQ));

  // R8: a period write while stopped leaves the counter alone
  a_r8_period_write_keeps_count: assert property (@(posedge clk) disable iff (!rstN)
    (haltQ && wrEn && regSel == SEL_PERIOD) |=> $stable(cntQ));

  // R5: reload bit never reads back set
  a_r5_reload_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == SEL_CTRL) |-> !rdData[RELOAD_BIT]);

  // R6: halt field reflects the last control write
  a_r6_halt_follows_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel == SEL_CTRL) |=> (haltQ == $past(wrData[HALT_BIT])));

endmodule

// File: tb/test_reload_timer.sv
`timescale 1ns/1ps
module test_reload_timer;

  localparam logic [15:0] HALT   = 16'h0100;
  localparam logic [15:0] RELOAD = 16'h0200;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = 16'h0;
  logic [15:0] rdData;
  logic        tickPulse;

  always #2.5 clk = ~clk;

  reload_timer i_reload_timer (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .tickPulse(tickPulse)
  );

  typedef struct {
    logic [1:0]  sel;
    logic [15:0] exp;
    string       tag;
  } rdItem_t;

  rdItem_t sbq[$];
  rdItem_t cur;
  int checks = 0;
  int errors = 0;
  int tickSeen = 0;
  bit finished = 1'b0;

  // model state
  logic [15:0] mCnt, mPer;
  logic [3:0]  mPre, mRat;
  int          mTicks;

  // monitor: pops expected reads and counts event pulses
  always @(negedge clk) begin
    if (rstN && tickPulse) tickSeen++;
    if (sbq.size() > 0) begin
      cur = sbq.pop_front();
      checks++;
      if (rdData !== cur.exp) begin
        errors++;
        $display("FAIL %s: select %0d read %h expected %h", cur.tag, cur.sel, rdData, cur.exp);
      end
    end
  end

  task automatic checkVal(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] s, input logic [15:0] e, input string t);
    rdItem_t it;
    it.sel = s; it.exp = e; it.tag = t;
    regSel = s;
    sbq.push_back(it);
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    @(posedge clk); #1;
    regSel = s; wrData = d; wrEn = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic modelRun(input int edges);
    for (int k = 0; k < edges; k++) begin
      if (mPre == 4'd0) begin
        mPre = mRat;
        if (mCnt == 16'd0) begin
          mCnt = mPer;
          mTicks++;
        end else begin
          mCnt = mCnt - 16'd1;
        end
      end else begin
        mPre = mPre - 4'd1;
      end
    end
  endtask

  // starts from a stopped timer, runs, stops, then checks
  task automatic runSeg(input logic [15:0] per, input logic [3:0] rat, input int n, input string tag);
    wr(2'd1, per);
    wr(2'd0, RELOAD | {12'h0, rat});
    tickSeen = 0;
    mPer = per; mRat = rat; mCnt = per; mPre = rat; mTicks = 0;
    repeat (n) @(posedge clk);
    wr(2'd0, HALT | {12'h0, rat});
    modelRun(n + 2);
    rd(2'd2, mCnt, {tag, " R2 counter"});
    rd(2'd0, HALT | {8'h0, mPre, rat}, {tag, " R4 prescaler"});
    checkVal({tag, " R3 event pulses"}, tickSeen, mTicks);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset values; timer runs at full rate from reset
    rd(2'd2, 16'hFFFF, "R1 counter reset");
    rd(2'd0, 16'h0000, "R1 control reset");
    rd(2'd1, 16'hFFFF, "R1 period reset");
    rd(2'd2, 16'hFFFC, "R2 ratio 0 counts every clock");
    checkVal("R1 no event after reset", tickSeen, 0);

    // R6/R8 writes while stopped
    wr(2'd0, HALT);
    wr(2'd2, 16'h1234);
    wr(2'd1, 16'h0005);
    repeat (10) @(posedge clk);
    rd(2'd2, 16'h1234, "R6 R8 counter frozen and written");
    rd(2'd1, 16'h0005, "R8 period written");
    rd(2'd0, HALT, "R6 control while stopped");

    // R5 reload while stopped, with new ratio
    wr(2'd0, HALT | RELOAD | 16'h0003);
    rd(2'd2, 16'h0005, "R5 reload copies period");
    rd(2'd0, 16'h0133, "R5 reload bit reads 0, prescaler gets ratio");

    // R7 prescaler field not writable
    wr(2'd0, HALT | 16'h00F3);
    rd(2'd0, 16'h0133, "R7 prescaler write ignored");

    // R8 period write leaves counter
    wr(2'd1, 16'h0009);
    rd(2'd2, 16'h0005, "R8 counter after period write");

    // R9 unused select
    wr(2'd3, 16'hFFFF);
    rd(2'd3, 16'h0000, "R9 unused reads 0");
    rd(2'd0, 16'h0133, "R9 control untouched");
    rd(2'd1, 16'h0009, "R9 period untouched");
    rd(2'd2, 16'h0005, "R9 counter untouched");

    // running segments
    runSeg(16'd5, 4'd3, 7,  "seg A");
    runSeg(16'd5, 4'd3, 22, "seg B borrow");
    runSeg(16'd2, 4'd0, 10, "seg C fast borrows");
    runSeg(16'd0, 4'd0, 3,  "seg D zero period");
    runSeg(16'd7, 4'd15, 40, "seg E max ratio");

    repeat (2) @(posedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule